// File: doc/BRIEF.md
# One-Time Fuse Programming Sequencer for a 6-bit Wiper

This block burns a wiper setting into a bank of one-time fuses and reports how the attempt went. It owns the wiper code register, which powers up at midscale while the part is unlocked. Writes to the register move the wiper freely until a program request arrives. The request comes from the top bit of a command byte, and it starts a fixed sequence. First a test fuse is strobed and read back. Then the six data fuses are strobed one per cycle, lowest bit first. The sensed fuse values are compared with the register. If they match, a lock fuse is strobed. The sequence stops at the first failing step with a 2-bit status that names that step.

The fuse array itself sits outside the block. The block drives one blow strobe per fuse and takes back one sense bit per fuse. Once the lock fuse senses as blown, the block takes its wiper code from the data fuses at every power-up instead of from midscale. From then on it refuses all further writes and program requests. The wiper code is also decoded into a one-hot select over the 64 ladder taps.

Top module: `otp_wiper_prog`

## Requirements
- R1: While the lock fuse (sense bit 7) is unblown, reset leaves the wiper at 32, the status at 00, busy low and no strobe driven, even if some data fuses are already blown.
- R2: A cycle with `prog_req` high, the block idle and the lock fuse unblown starts a sequence. Busy is high from the next cycle until a terminal status is reached. With `prog_req` low, nothing starts.
- R3: In the first busy cycle the test fuse (strobe bit 6) is strobed, unless it already senses as blown. If sense bit 6 is still low in the second busy cycle, the sequence ends: in the third cycle busy is low and the status is 01.
- R4: In busy cycles 3 to 8, data fuse b (strobe bit b) is strobed in cycle 3+b, bit 0 first. A fuse is strobed only when code bit b is 1 and the fuse is not already sensed as blown. At most one strobe is high in any cycle.
- R5: In busy cycle 9, sense bits 5..0 are compared with the wiper code. On a mismatch, cycle 10 shows busy low, status 10 and no lock strobe.
- R6: On a match, the lock fuse (strobe bit 7) is strobed in busy cycle 10. Cycle 11 shows busy low, status 11 and the lock indication high.
- R7: While locked, program requests start nothing and wiper writes change nothing. Busy stays low and no strobe rises.
- R8: A reset while the lock fuse senses as blown gives status 11, the lock indication high and a wiper equal to sense bits 5..0.
- R9: A program request while busy is ignored. The running sequence ends in the same cycle it would have ended without it.
- R10: A retry after status 10 clears the status to 00 in its first busy cycle. It strobes no fuse that already senses as blown, and it succeeds once the sensed data equal the code.
- R11: `tap_sel` has exactly one bit set, at the index equal to the wiper code. Code 0 selects bit 0, the bottom-terminal tap.
- R12: An unlocked, idle write of `wr_code` with `wr_en` shows on `wiper` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Wiper register write strobe |
| wr_code | input | 6 | Wiper code to write |
| prog_req | input | 1 | Program request (top bit of the command byte) |
| fuse_sense | input | 8 | Fuse read-back: 5..0 data, 6 test, 7 lock |
| fuse_blow | output | 8 | Fuse blow strobes, same bit layout as sense |
| status | output | 2 | 00 ready, 01 test fuse failed, 10 data mismatch, 11 locked |
| busy | output | 1 | A programming sequence is running |
| locked | output | 1 | Lock fuse senses as blown |
| wiper | output | 6 | Active wiper code |
| tap_sel | output | 64 | One-hot ladder tap select |

## Verification
Each result has a fixed cycle, counted from the clock edge that samples the request. The test strobe is due in busy cycle 1. Data strobe b is due in cycle 3+b. The test-fuse abort is visible in cycle 3, the mismatch abort in cycle 10, and the lock strobe in cycle 10 with status 11 in cycle 11. The bench walks these cycles one falling edge at a time. It compares the whole strobe vector, busy and status against values it works out from the code and from its own fuse model's state before the sequence. Wiper writes and reset effects are sampled on the falling edge one cycle after the causing edge.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [1:0] {
    ST_READY  = 2'b00,
    ST_TESTF  = 2'b01,
    ST_DATAF  = 2'b10,
    ST_LOCKED = 2'b11
  } otp_status_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TEST,
    SQ_TCHK,
    SQ_DATA,
    SQ_VERIFY,
    SQ_LOCK
  } otp_state_e;

  // one-hot tap decode of a code (64 taps at the default width)
  function automatic logic [63:0] tap_onehot(input logic [5:0] code);
    logic [63:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  // sensed data fuses against the code to be stored
  function automatic logic fuse_match(input logic [5:0] sensed, input logic [5:0] code);
    return (sensed ^ code) == 6'd0;
  endfunction

endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_prog_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W+1:0] fuse_sense,
  output logic [CODE_W+1:0] fuse_blow,
  output logic [1:0]        status,
  output logic              busy,
  output logic              locked
);
  localparam int TEST_IDX = CODE_W;
  localparam int LOCK_IDX = CODE_W + 1;
  localparam int CNT_W    = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

  otp_state_e        state_q;
  logic [CNT_W-1:0]  bit_q;
  logic [1:0]        status_q;

  // named internal events for the assertions
  logic start_evt, test_fail_evt, data_fail_evt, lock_evt;

  assign locked        = fuse_sense[LOCK_IDX];
  assign busy          = (state_q != SQ_IDLE);
  assign start_evt     = prog_req && (state_q == SQ_IDLE) && !locked;
  assign test_fail_evt = (state_q == SQ_TCHK) && !fuse_sense[TEST_IDX];
  assign data_fail_evt = (state_q == SQ_VERIFY) && !fuse_match(fuse_sense[CODE_W-1:0], code);
  assign lock_evt      = (state_q == SQ_LOCK);
  assign status        = locked ? ST_LOCKED : status_q;

  always_comb begin
    fuse_blow = '0;
    case (state_q)
      SQ_TEST: fuse_blow[TEST_IDX] = !fuse_sense[TEST_IDX];
      SQ_DATA: fuse_blow[bit_q]    = code[bit_q] && !fuse_sense[bit_q];
      SQ_LOCK: fuse_blow[LOCK_IDX] = 1'b1;
      default: fuse_blow = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      bit_q    <= '0;
      status_q <= ST_READY;
    end else begin
      case (state_q)
        SQ_IDLE: if (start_evt) begin
          state_q  <= SQ_TEST;
          status_q <= ST_READY;
        end
        SQ_TEST: state_q <= SQ_TCHK;
        SQ_TCHK: if (test_fail_evt) begin
          state_q  <= SQ_IDLE;
          status_q <= ST_TESTF;
        end else begin
          state_q <= SQ_DATA;
          bit_q   <= '0;
        end
        SQ_DATA: if (bit_q == LAST_BIT) state_q <= SQ_VERIFY;
                 else bit_q <= bit_q + 1'b1;
        SQ_VERIFY: if (data_fail_evt) begin
          state_q  <= SQ_IDLE;
          status_q <= ST_DATAF;
        end else state_q <= SQ_LOCK;
        SQ_LOCK: begin
          state_q  <= SQ_IDLE;
          status_q <= ST_LOCKED;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fuse_blow));
  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && status_q == ST_READY);
  p_locked_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !busy |=> !busy);
  p_test_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail_evt |=> !busy && status_q == ST_TESTF);
  p_data_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_fail_evt |=> !busy && status_q == ST_DATAF && fuse_blow == '0);
  p_lock_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> !busy && status_q == ST_LOCKED);
  p_busy_ends_terminal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status_q != ST_READY);

endmodule

// File: rtl/otp_wiper_src.sv
module otp_wiper_src
  import otp_prog_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CODE_W-1:0]    wr_code,
  input  logic                 busy,
  input  logic                 locked,
  input  logic [CODE_W-1:0]    fuse_data,
  output logic [CODE_W-1:0]    reg_code,
  output logic [CODE_W-1:0]    wiper,
  output logic [(1<<CODE_W)-1:0] tap_sel
);
  localparam int TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(TAPS / 2);

  logic [CODE_W-1:0] wiper_q;
  logic              wr_ok;

  assign wr_ok    = wr_en && !busy && !locked;
  assign reg_code = wiper_q;
  assign wiper    = locked ? fuse_data : wiper_q;

  always_comb begin
    tap_sel = '0;
    tap_sel[wiper] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= MIDSCALE;
    else if (wr_ok) wiper_q <= wr_code;
  end

  p_tap_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && $stable(locked) |=> $stable(wiper));

endmodule

// File: rtl/otp_wiper_prog.sv
module otp_wiper_prog
  import otp_prog_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic                    prog_req,
  input  logic [CODE_W+1:0]       fuse_sense,
  output logic [CODE_W+1:0]       fuse_blow,
  output logic [1:0]              status,
  output logic                    busy,
  output logic                    locked,
  output logic [CODE_W-1:0]       wiper,
  output logic [(1<<CODE_W)-1:0]  tap_sel
);
  logic [CODE_W-1:0] reg_code;

  otp_seq #(.CODE_W(CODE_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_req   (prog_req),
    .code       (reg_code),
    .fuse_sense (fuse_sense),
    .fuse_blow  (fuse_blow),
    .status     (status),
    .busy       (busy),
    .locked     (locked)
  );

  otp_wiper_src #(.CODE_W(CODE_W)) wsrc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_code   (wr_code),
    .busy      (busy),
    .locked    (locked),
    .fuse_data (fuse_sense[CODE_W-1:0]),
    .reg_code  (reg_code),
    .wiper     (wiper),
    .tap_sel   (tap_sel)
  );

endmodule

// File: tb/otp_wiper_prog_tb.sv
`timescale 1ns/1ps
module otp_wiper_prog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_code = '0;
  logic        prog_req = 1'b0;
  logic [7:0]  sense;
  logic [7:0]  fuse_blow;
  logic [1:0]  status;
  logic        busy, locked;
  logic [5:0]  wiper;
  logic [63:0] tap_sel;

  logic [7:0]  stuck = '0;
  logic        wipe = 1'b1;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  // behavioural fuse array: survives reset, a stuck fuse never blows
  always @(posedge clk) begin
    if (wipe) sense <= '0;
    else      sense <= sense | (fuse_blow & ~stuck);
  end

  otp_wiper_prog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .prog_req(prog_req), .fuse_sense(sense), .fuse_blow(fuse_blow),
    .status(status), .busy(busy), .locked(locked), .wiper(wiper),
    .tap_sel(tap_sel)
  );

  // {code, stuck mask, expected status}
  localparam logic [15:0] VEC [0:5] = '{
    {6'h2A, 8'h00, 2'b11},
    {6'h00, 8'h00, 2'b11},
    {6'h3F, 8'h00, 2'b11},
    {6'h15, 8'h40, 2'b01},
    {6'h15, 8'h02, 2'b11},
    {6'h15, 8'h04, 2'b10}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic power_up(input logic fresh);
    @(negedge clk);
    rst_n = 1'b0;
    wipe = fresh;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wipe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_code(input logic [5:0] c);
    wr_en = 1'b1; wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_blow(input int k, input logic [5:0] c,
                                          input logic [7:0] pre, input logic [1:0] st);
    if (k == 1) return pre[6] ? 8'h00 : 8'h40;
    if (k >= 3 && k <= 8) return (c[k-3] && !pre[k-3]) ? (8'h01 << (k-3)) : 8'h00;
    if (k == 10 && st == 2'b11) return 8'h80;
    return 8'h00;
  endfunction

  // runs one request from a negedge; extra_at > 0 pulses a second request then
  task automatic run_seq(input logic [5:0] c, input logic [1:0] st, input int extra_at);
    logic [7:0] pre;
    int n;
    write_code(c);
    pre = sense;
    n = (st == 2'b01) ? 2 : (st == 2'b10) ? 9 : 10;
    prog_req = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      prog_req = (k == extra_at);
      chk(busy === 1'b1, "R2 busy during sequence", busy, 1);
      chk(fuse_blow === exp_blow(k, c, pre, st), "R3/R4/R6 strobe",
          fuse_blow, exp_blow(k, c, pre, st));
      if (k == 1) chk(status === 2'b00, "R10 status cleared at start", status, 0);
    end
    @(negedge clk);
    prog_req = 1'b0;
    chk(busy === 1'b0, "R9 sequence end cycle", busy, 0);
    chk(status === st, "R3/R5/R6 terminal status", status, st);
    chk(fuse_blow === 8'h00, "R5 no strobe after end", fuse_blow, 0);
  endtask

  initial begin
    power_up(1'b1);
    // R1 reset state
    chk(wiper === 6'd32 && status === 2'b00 && !busy && fuse_blow === 0,
        "R1 reset state", {status, busy, wiper}, {2'b00, 1'b0, 6'd32});
    chk(tap_sel === (64'd1 << 32), "R11 midscale tap", tap_sel, 64'd1 << 32);
    // R12 / R11 writes
    write_code(6'd0);
    chk(wiper === 6'd0, "R12 write visible", wiper, 0);
    chk(tap_sel === 64'd1, "R11 code 0 bottom tap", tap_sel, 1);
    write_code(6'd63);
    chk(tap_sel === (64'd1 << 63), "R11 top tap", tap_sel, 64'd1 << 63);
    // R2 no request, nothing starts
    @(negedge clk);
    chk(busy === 1'b0, "R2 idle without request", busy, 0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      power_up(1'b1);
      stuck = VEC[i][9:2];
      run_seq(VEC[i][15:10], VEC[i][1:0], 0);
    end

    // R1 data fuses blown, no lock: reset gives midscale
    stuck = '0;
    power_up(1'b0);
    chk(wiper === 6'd32 && status === 2'b00 && !locked, "R1 unlocked reset",
        {status, locked, wiper}, {2'b00, 1'b0, 6'd32});
    // R10 retry skips blown fuses (test, bit0, bit4) and locks
    run_seq(6'h15, 2'b11, 0);
    chk(locked === 1'b1 && wiper === 6'h15, "R6 locked with code", {locked, wiper}, {1'b1, 6'h15});

    // R7 requests and writes ignored when locked
    prog_req = 1'b1; wr_en = 1'b1; wr_code = 6'h01;
    @(negedge clk);
    prog_req = 1'b0; wr_en = 1'b0;
    chk(busy === 1'b0 && fuse_blow === 8'h00, "R7 request ignored", {busy, fuse_blow}, 0);
    @(negedge clk);
    chk(wiper === 6'h15 && busy === 1'b0, "R7 write ignored", wiper, 6'h15);

    // R8 locked power-on loads fuses
    power_up(1'b0);
    chk(wiper === 6'h15 && status === 2'b11 && locked, "R8 locked power-on",
        {status, locked, wiper}, {2'b11, 1'b1, 6'h15});
    chk(tap_sel === (64'd1 << 21), "R11 tap from fuses", tap_sel, 64'd1 << 21);

    // R9 second request mid-sequence
    power_up(1'b1);
    run_seq(6'h2A, 2'b11, 4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule